// File: doc/BRIEF.md
# Per-Warp Register Hazard Scoreboard

This block sits in the issue stage of a multi-warp SIMT core. It decides each cycle whether the decoded instruction offered by one warp may issue. Each warp owns a bitmap with one bit per architectural register. The bit is set while a write to that register is in flight. Each warp also keeps a small counter per register for operand reads that were issued but not yet collected. The block works at warp granularity: a warp of 32 threads is one entry, never 32.

A candidate carries a warp index, an optional destination register and up to three optional source registers. The block builds a dependency vector from these fields and the warp's stored state. The candidate is ready only when that vector is zero and the candidate is valid. An issue strobe commits the candidate: it marks the destination pending and counts one read for each enabled source. A writeback port clears a pending bit. An operand-read-done port takes back the reads of an earlier issue. Writebacks and read-done events are seen in the same cycle as a candidate, so a hazard that ends in the current cycle does not stall it.

Top module: `warp_hazard_sb`

## Requirements
- R1: After reset every pending bit and every read counter in every warp is zero, so any valid candidate is ready with an all-zero dependency vector.
- R2: Read-after-write: if enabled source slot k names a register whose write is pending in the candidate's warp, `cand_dep[k]` is 1 (slots 0..2 map to bits 0..2).
- R3: Write-after-write: if the enabled destination names a register whose write is pending in the candidate's warp, `cand_dep[3]` is 1.
- R4: Write-after-read: if the enabled destination names a register with a nonzero read count in the candidate's warp, `cand_dep[4]` is 1.
- R5: The read counter is 2 bits wide. If enabled source slot k names a register whose count plus the number of enabled slots naming that register would exceed 3, `cand_dep[5+k]` is 1.
- R6: A writeback clears the pending bit of its warp and register at the next edge. A writeback in the same cycle already hides that bit from the candidate's dependency vector.
- R7: When an issue and a writeback name the same warp and destination register in one cycle, the bit is cleared first and then set, so it ends up set.
- R8: A read-done event subtracts one from the count of each register named by its enabled slots, and counts as several events when several slots name the same register. The event already lowers the counts the candidate sees in the same cycle.
- R9: The state of one warp never affects the dependency vector of a candidate from another warp.
- R10: Disabled source slots and a disabled destination raise no dependency bit. `cand_ready` is 0 whenever `cand_valid` is 0.
- R11: `cand_ready` equals `cand_valid` AND (`cand_dep` == 0). An issue strobe sets the destination's pending bit and adds one read to the count of each enabled source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate is offered this cycle |
| cand_warp | input | 3 | Warp index of the candidate |
| cand_dst_en | input | 1 | Candidate writes a destination register |
| cand_dst | input | 5 | Destination register |
| cand_src_en | input | 3 | Per-slot source enable |
| cand_src | input | 15 | Source registers, slot k at bits [5k+4:5k] |
| issue_fire | input | 1 | Candidate is issued this cycle |
| wb_valid | input | 1 | Writeback event |
| wb_warp | input | 3 | Warp of the writeback |
| wb_reg | input | 5 | Register written back |
| rdd_valid | input | 1 | Operand-read-done event |
| rdd_warp | input | 3 | Warp of the read-done event |
| rdd_src_en | input | 3 | Per-slot enable of the finished reads |
| rdd_src | input | 15 | Registers whose reads finished, slot k at bits [5k+4:5k] |
| cand_dep | output | 8 | Dependency vector: [2:0] RAW per slot, [3] WAW, [4] WAR, [7:5] read-count full per slot |
| cand_ready | output | 1 | Candidate may issue |

## Verification
The assertions rely on three rules for the inputs. The issue strobe is raised only when `cand_ready` is high. A read-done event never names more reads of a register than are outstanding. A writeback names a register that has a write pending or lets the same-cycle issue set it again. The bench keeps its own model of every bitmap and counter. It raises the issue strobe only when its model predicts a ready candidate. It draws writebacks and read-done events only from registers the model holds as pending or counted. In the random phase, candidates use two warps and eight registers so that hazards and same-cycle collisions occur often.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Bit positions inside the dependency vector for NS source slots.
  function automatic int raw_bit(input int k);
    return k;
  endfunction

  function automatic int waw_bit(input int ns);
    return ns;
  endfunction

  function automatic int war_bit(input int ns);
    return ns + 1;
  endfunction

  function automatic int full_bit(input int ns, input int k);
    return ns + 2 + k;
  endfunction
endpackage

// File: rtl/sb_pend_bits.sv
module sb_pend_bits #(
  parameter int NW = 8,
  parameter int NR = 32,
  parameter int WW = $clog2(NW),
  parameter int RW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [WW-1:0] set_warp,
  input  logic [RW-1:0] set_reg,
  input  logic          clr_en,
  input  logic [WW-1:0] clr_warp,
  input  logic [RW-1:0] clr_reg,
  input  logic [WW-1:0] rd_warp,
  output logic [NR-1:0] rd_row
);
  logic [NR-1:0] pend_q [NW];

  // The set is written after the clear, so a set wins on a shared bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NW; w++) pend_q[w] <= '0;
    end else begin
      if (clr_en) pend_q[clr_warp][clr_reg] <= 1'b0;
      if (set_en) pend_q[set_warp][set_reg] <= 1'b1;
    end
  end

  assign rd_row = pend_q[rd_warp];

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_warp)][$past(set_reg)]);

  // R6
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg))
    |=> !pend_q[$past(clr_warp)][$past(clr_reg)]);

  // R3
  no_double_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> (!pend_q[set_warp][set_reg] ||
                (clr_en && clr_warp == set_warp && clr_reg == set_reg)));
endmodule

// File: rtl/sb_read_cnt.sv
module sb_read_cnt #(
  parameter int NW = 8,
  parameter int NR = 32,
  parameter int NS = 3,
  parameter int CW = 2,
  parameter int WW = $clog2(NW),
  parameter int RW = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [WW-1:0]    inc_warp,
  input  logic [NS-1:0]    inc_mask,
  input  logic [NS*RW-1:0] inc_regs,
  input  logic             dec_en,
  input  logic [WW-1:0]    dec_warp,
  input  logic [NS-1:0]    dec_mask,
  input  logic [NS*RW-1:0] dec_regs,
  input  logic [WW-1:0]    rd_warp,
  output logic [NR*CW-1:0] rd_row
);
  localparam int SW = CW + $clog2(NS + 1) + 1;
  localparam logic [SW-1:0] ONE  = SW'(1);
  localparam logic [SW-1:0] CMAX = SW'((1 << CW) - 1);

  logic [NW*NR*CW-1:0] cnt_flat;

  for (genvar w = 0; w < NW; w++) begin : g_warp
    for (genvar r = 0; r < NR; r++) begin : g_reg
      logic [CW-1:0] cnt_q;
      logic [SW-1:0] inc_n, dec_n, sum_n;

      always_comb begin
        inc_n = '0;
        dec_n = '0;
        for (int k = 0; k < NS; k++) begin
          if (inc_en && inc_warp == WW'(w) && inc_mask[k] &&
              inc_regs[k*RW +: RW] == RW'(r))
            inc_n = inc_n + ONE;
          if (dec_en && dec_warp == WW'(w) && dec_mask[k] &&
              dec_regs[k*RW +: RW] == RW'(r))
            dec_n = dec_n + ONE;
        end
        sum_n = SW'(cnt_q) + inc_n - dec_n;
      end

      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= sum_n[CW-1:0];
      end

      assign cnt_flat[(w*NR + r)*CW +: CW] = cnt_q;

      // R8
      no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (SW'(cnt_q) + inc_n) >= dec_n);

      // R5
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        sum_n <= CMAX);
    end
  end

  assign rd_row = cnt_flat[int'(rd_warp)*NR*CW +: NR*CW];
endmodule

// File: rtl/sb_dep_vec.sv
module sb_dep_vec
  import sb_pkg::*;
#(
  parameter int NR = 32,
  parameter int NS = 3,
  parameter int CW = 2,
  parameter int WW = 3,
  parameter int RW = $clog2(NR),
  parameter int DW = 2*NS + 2
) (
  input  logic [WW-1:0]    cand_warp,
  input  logic             cand_dst_en,
  input  logic [RW-1:0]    cand_dst,
  input  logic [NS-1:0]    cand_src_en,
  input  logic [NS*RW-1:0] cand_src,
  input  logic [NR-1:0]    pend_row,
  input  logic [NR*CW-1:0] cnt_row,
  input  logic             wb_valid,
  input  logic [WW-1:0]    wb_warp,
  input  logic [RW-1:0]    wb_reg,
  input  logic             rdd_valid,
  input  logic [WW-1:0]    rdd_warp,
  input  logic [NS-1:0]    rdd_src_en,
  input  logic [NS*RW-1:0] rdd_src,
  output logic [DW-1:0]    dep
);
  localparam int SW = CW + $clog2(NS + 1) + 1;
  localparam logic [SW-1:0] ONE  = SW'(1);
  localparam logic [SW-1:0] CMAX = SW'((1 << CW) - 1);

  // Number of enabled slots in regs that name register r.
  function automatic logic [SW-1:0] n_same(input logic [RW-1:0] r,
                                           input logic [NS-1:0] en,
                                           input logic [NS*RW-1:0] regs);
    logic [SW-1:0] n;
    n = '0;
    for (int j = 0; j < NS; j++)
      if (en[j] && regs[j*RW +: RW] == r) n = n + ONE;
    return n;
  endfunction

  logic          wb_hit, rd_hit;
  logic [RW-1:0] s;
  logic [SW-1:0] eff;

  always_comb begin
    dep    = '0;
    wb_hit = wb_valid  && wb_warp  == cand_warp;
    rd_hit = rdd_valid && rdd_warp == cand_warp;
    s      = '0;
    eff    = '0;
    for (int k = 0; k < NS; k++) begin
      s = cand_src[k*RW +: RW];
      eff = SW'(cnt_row[int'(s)*CW +: CW]) -
            (rd_hit ? n_same(s, rdd_src_en, rdd_src) : '0);
      dep[raw_bit(k)]      = cand_src_en[k] && pend_row[s] && !(wb_hit && wb_reg == s);
      dep[full_bit(NS, k)] = cand_src_en[k] &&
                             ((eff + n_same(s, cand_src_en, cand_src)) > CMAX);
    end
    eff = SW'(cnt_row[int'(cand_dst)*CW +: CW]) -
          (rd_hit ? n_same(cand_dst, rdd_src_en, rdd_src) : '0);
    dep[waw_bit(NS)] = cand_dst_en && pend_row[cand_dst] && !(wb_hit && wb_reg == cand_dst);
    dep[war_bit(NS)] = cand_dst_en && (eff != '0);
  end
endmodule

// File: rtl/warp_hazard_sb.sv
module warp_hazard_sb #(
  parameter int NW = 8,
  parameter int NR = 32,
  parameter int NS = 3,
  parameter int CW = 2,
  localparam int WW = $clog2(NW),
  localparam int RW = $clog2(NR),
  localparam int DW = 2*NS + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cand_valid,
  input  logic [WW-1:0]    cand_warp,
  input  logic             cand_dst_en,
  input  logic [RW-1:0]    cand_dst,
  input  logic [NS-1:0]    cand_src_en,
  input  logic [NS*RW-1:0] cand_src,
  input  logic             issue_fire,
  input  logic             wb_valid,
  input  logic [WW-1:0]    wb_warp,
  input  logic [RW-1:0]    wb_reg,
  input  logic             rdd_valid,
  input  logic [WW-1:0]    rdd_warp,
  input  logic [NS-1:0]    rdd_src_en,
  input  logic [NS*RW-1:0] rdd_src,
  output logic [DW-1:0]    cand_dep,
  output logic             cand_ready
);
  logic [NR-1:0]    pend_row;
  logic [NR*CW-1:0] cnt_row;

  sb_pend_bits #(.NW(NW), .NR(NR), .WW(WW), .RW(RW)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_en   (issue_fire && cand_dst_en),
    .set_warp (cand_warp),
    .set_reg  (cand_dst),
    .clr_en   (wb_valid),
    .clr_warp (wb_warp),
    .clr_reg  (wb_reg),
    .rd_warp  (cand_warp),
    .rd_row   (pend_row)
  );

  sb_read_cnt #(.NW(NW), .NR(NR), .NS(NS), .CW(CW), .WW(WW), .RW(RW)) u_rcnt (
    .clk      (clk),
    .rst      (rst),
    .inc_en   (issue_fire),
    .inc_warp (cand_warp),
    .inc_mask (cand_src_en),
    .inc_regs (cand_src),
    .dec_en   (rdd_valid),
    .dec_warp (rdd_warp),
    .dec_mask (rdd_src_en),
    .dec_regs (rdd_src),
    .rd_warp  (cand_warp),
    .rd_row   (cnt_row)
  );

  sb_dep_vec #(.NR(NR), .NS(NS), .CW(CW), .WW(WW), .RW(RW), .DW(DW)) u_dep (
    .cand_warp   (cand_warp),
    .cand_dst_en (cand_dst_en),
    .cand_dst    (cand_dst),
    .cand_src_en (cand_src_en),
    .cand_src    (cand_src),
    .pend_row    (pend_row),
    .cnt_row     (cnt_row),
    .wb_valid    (wb_valid),
    .wb_warp     (wb_warp),
    .wb_reg      (wb_reg),
    .rdd_valid   (rdd_valid),
    .rdd_warp    (rdd_warp),
    .rdd_src_en  (rdd_src_en),
    .rdd_src     (rdd_src),
    .dep         (cand_dep)
  );

  assign cand_ready = cand_valid && (cand_dep == '0);

  // R11
  issue_ok_chk: assert property (@(posedge clk) disable iff (rst)
    issue_fire |-> cand_ready);
endmodule

// File: tb/warp_hazard_sb_bench.sv
`timescale 1ns/1ps
module warp_hazard_sb_bench;
  logic       clk = 0;
  logic       rst;
  logic       cv, cde, fire, wv, rv;
  logic [2:0] cw, wwp, rwp, cse, rse;
  logic [4:0] cd, wr;
  logic [4:0] cs [3];
  logic [4:0] rs [3];
  logic [7:0] dep;
  logic       rdy;

  bit mp [8][32];
  int mc [8][32];
  int checks = 0, errs = 0, cyc = 0;

  always #5 clk = ~clk;

  warp_hazard_sb u_warp_hazard_sb (
    .clk(clk), .rst(rst),
    .cand_valid(cv), .cand_warp(cw), .cand_dst_en(cde), .cand_dst(cd),
    .cand_src_en(cse), .cand_src({cs[2], cs[1], cs[0]}),
    .issue_fire(fire),
    .wb_valid(wv), .wb_warp(wwp), .wb_reg(wr),
    .rdd_valid(rv), .rdd_warp(rwp), .rdd_src_en(rse), .rdd_src({rs[2], rs[1], rs[0]}),
    .cand_dep(dep), .cand_ready(rdy)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      summary();
    end
  end

  function automatic int eff(input int w, input logic [4:0] r);
    int v = mc[w][r];
    if (rv && rwp == w[2:0])
      for (int j = 0; j < 3; j++) if (rse[j] && rs[j] == r) v--;
    return v;
  endfunction

  function automatic logic [7:0] exp_dep();
    logic [7:0] e = '0;
    for (int k = 0; k < 3; k++) begin
      if (cse[k]) begin
        int dup = 0;
        if (mp[cw][cs[k]] && !(wv && wwp == cw && wr == cs[k])) e[k] = 1'b1;
        for (int j = 0; j < 3; j++) if (cse[j] && cs[j] == cs[k]) dup++;
        if (eff(cw, cs[k]) + dup > 3) e[5+k] = 1'b1;
      end
    end
    if (cde) begin
      if (mp[cw][cd] && !(wv && wwp == cw && wr == cd)) e[3] = 1'b1;
      if (eff(cw, cd) != 0) e[4] = 1'b1;
    end
    return e;
  endfunction

  // Called at a negedge with inputs driven; checks, then crosses one edge.
  task automatic step(input string tag, input bit want_fire);
    logic [7:0] e;
    logic er;
    #1;
    e  = exp_dep();
    er = cv && (e == 8'h00);
    checks++;
    if (dep !== e || rdy !== er) begin
      errs++;
      $display("FAIL %s: dep=%b ready=%b expected dep=%b ready=%b", tag, dep, rdy, e, er);
    end
    fire = want_fire && er;
    @(posedge clk);
    if (wv) mp[wwp][wr] = 0;
    if (fire && cde) mp[cw][cd] = 1;
    if (rv) for (int k = 0; k < 3; k++) if (rse[k]) mc[rwp][rs[k]]--;
    if (fire) for (int k = 0; k < 3; k++) if (cse[k]) mc[cw][cs[k]]++;
    @(negedge clk);
    fire = 0; wv = 0; rv = 0;
  endtask

  initial begin
    rst = 1; cv = 0; cde = 0; fire = 0; wv = 0; rv = 0;
    cw = 0; wwp = 0; rwp = 0; cse = 0; rse = 0; cd = 0; wr = 0;
    for (int k = 0; k < 3; k++) begin cs[k] = 0; rs[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: every warp and register is hazard-free after reset
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 32; r++) begin
        cv = 1; cw = 3'(w); cde = 1; cd = 5'(r); cse = 3'b111;
        for (int k = 0; k < 3; k++) cs[k] = 5'(r);
        step("R1", 0);
      end

    // R2: read after write
    cw = 2; cde = 1; cd = 5; cse = 0; step("R2 setup", 1);
    cde = 0; cse = 3'b010; cs[1] = 5; step("R2", 0);
    // R3: write after write
    cde = 1; cd = 5; cse = 0; step("R3", 0);
    // R9: another warp is unaffected
    cw = 3; cse = 3'b001; cs[0] = 5; step("R9", 1);
    // R6: writeback bypass, then cleared
    cw = 2; cde = 0; cse = 3'b001; cs[0] = 5;
    wv = 1; wwp = 2; wr = 5; step("R6 bypass", 0);
    step("R6", 0);
    // R7: same-cycle writeback and issue leave the bit set
    cde = 1; cd = 7; cse = 0; step("R7 setup", 1);
    wv = 1; wwp = 2; wr = 7; step("R7 same cycle", 1);
    cde = 0; cse = 3'b001; cs[0] = 7; step("R7", 0);
    // R4: write after read
    cw = 4; cde = 0; cse = 3'b001; cs[0] = 9; step("R4 setup", 1);
    cde = 1; cd = 9; cse = 0; step("R4", 0);
    // R8: read-done bypass, then count back at zero
    rv = 1; rwp = 4; rse = 3'b001; rs[0] = 9; step("R8 bypass", 0);
    step("R8", 0);
    // R5: read counter full
    cw = 5; cde = 0; cse = 3'b111; cs[0] = 11; cs[1] = 11; cs[2] = 11; step("R5 setup", 1);
    cse = 3'b001; step("R5", 0);
    cse = 3'b011; rv = 1; rwp = 5; rse = 3'b011; rs[0] = 11; rs[1] = 11;
    step("R5 bypass", 1);
    // R10: disabled fields and invalid candidate
    cw = 2; cse = 3'b000; cs[0] = 7; cde = 0; cv = 1; step("R10 disabled", 0);
    cv = 0; cse = 3'b001; step("R10 invalid", 0);

    // R11: random traffic on two warps and eight registers
    for (int i = 0; i < 4000; i++) begin
      int w, r;
      cv = ($urandom % 8) != 0;
      cw = 3'($urandom % 2);
      cde = 1'($urandom % 2);
      cd = 5'($urandom % 8);
      cse = 3'($urandom % 8);
      for (int k = 0; k < 3; k++) cs[k] = 5'($urandom % 8);
      w = $urandom % 2; r = $urandom % 8;
      if (($urandom % 2) == 0 && mp[w][r]) begin wv = 1; wwp = 3'(w); wr = 5'(r); end
      w = $urandom % 2; r = $urandom % 8;
      if (($urandom % 2) == 0 && mc[w][r] > 0) begin
        rv = 1; rwp = 3'(w); rse = 3'b001; rs[0] = 5'(r); rs[1] = 5'(r);
        if (mc[w][r] >= 2 && ($urandom % 2) == 0) rse = 3'b011;
      end
      step("R11", ($urandom % 10) < 7);
    end

    summary();
  end
endmodule